// File: doc/BRIEF.md
# Debug Watchpoint Address Comparator

This block watches the data side of a processor for loads and stores that touch a programmed window of bytes. Software programs two registers: a value word that gives the watched address and a control word that arms the watchpoint, picks which access kinds it reacts to, and says how wide the window is. The window is either a naturally aligned power-of-two region taken from a mask-size field, or a short run of bytes picked by an eight-bit byte-select field next to the value address.

Each cycle the access port presents an address, a byte count and a load/store flag. The block raises `hit` combinationally in the same cycle when any byte of that access falls inside the window and the access kind passes the filter, so the pipeline can cancel the access before it takes effect. Reserved encodings disarm the watchpoint rather than guessing a meaning, and register writes take effect from the following cycle.

Top module: `wpt_cmp`

## Requirements
- R1: Control bit 0 arms the watchpoint; while it is 0, `hit` stays low for every access.
- R2: Control bits [4:3] filter the access kind: 2'b01 reacts to loads only (`acc_is_store`=0), 2'b10 to stores only (`acc_is_store`=1), 2'b11 to both, and 2'b00 disarms the watchpoint.
- R3: The mask-size field is control bits [27:24]; the values 1 and 2 disarm the watchpoint.
- R4: A mask-size value m of 3 to 15 watches the aligned region of 2^m bytes that contains the value address; the low m bits of the value are ignored, and so is the byte-select field.
- R5: With mask-size 0, control bits [12:5] are the byte-select field, bit i selecting the byte at value address + i; an all-zero byte-select disarms the watchpoint.
- R6: When bit 2 of the stored value is 1, byte-select bits [7:4] are treated as 0; if what remains is zero the watchpoint is disarmed.
- R7: Only the first contiguous run of ones in the byte-select field, counted from its lowest set bit, is watched; set bits above that run are ignored.
- R8: A write to the value register stores bits [1:0] as 0 and bits [63:49] as copies of written bit 48.
- R9: `hit` requires `acc_valid`=1, a byte count `acc_size` of 1 to 15, and at least one byte of [acc_addr, acc_addr+acc_size) inside the window; a byte count of 0 never hits.
- R10: `hit` is a combinational function of the access inputs and reaches its value in the same cycle the access is presented.
- R11: Both registers reset to zero (no hit), and a register write changes the window and filter starting with the cycle after the write edge; accesses in the write cycle still see the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| val_we | input | 1 | Write strobe for the value register |
| val_wdata | input | 64 | Data for the value register |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | Data for the control register |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 64 | Byte address of the access |
| acc_size | input | 4 | Number of bytes accessed |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | Access touches the watched window and passes the filter |

## Verification
The hardest situation to reach from the ports is a byte-select window whose shape depends on the stored value as well as the control word: bit 2 of the value halving the select field, combined with a select pattern that has a gap, so that only part of the programmed bytes are really watched. Directed cases build these combinations deliberately, and the random phase draws control words with biased mask-size, byte-select and type fields and aims access addresses within a few bytes of the value address (or across the mask region), so that partial overlaps at both ends of the window and the half-field case come up often.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

   // access-kind filter encoding held in the control word
   typedef enum logic [1:0] {
      WT_NONE  = 2'b00,
      WT_LOAD  = 2'b01,
      WT_STORE = 2'b10,
      WT_ANY   = 2'b11
   } wtype_e;

   typedef struct packed {
      logic armed;
      logic rd_ok;
      logic wr_ok;
   } wfilt_t;

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs #(
   parameter int unsigned VA_W     = 64,
   parameter int unsigned SEXT_BIT = 48,
   parameter int unsigned CTL_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             val_we,
   input  logic [VA_W-1:0]  val_wdata,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [VA_W-1:0]  val_q,
   output logic [CTL_W-1:0] ctl_q
);
   localparam int unsigned EXT_W = VA_W - SEXT_BIT - 1;

   logic [VA_W-1:0] val_cond;

   generate
      if (EXT_W == 0) begin : g_noext
         assign val_cond = {val_wdata[VA_W-1:2], 2'b00};
      end else begin : g_ext
         assign val_cond = {{EXT_W{val_wdata[SEXT_BIT]}},
                            val_wdata[SEXT_BIT:2], 2'b00};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         ctl_q <= '0;
      end else begin
         if (val_we) val_q <= val_cond;
         if (ctl_we) ctl_q <= ctl_wdata;
      end
   end
endmodule

// File: rtl/wpt_decode.sv
module wpt_decode
   import wpt_pkg::*;
#(
   parameter int unsigned VA_W     = 64,
   parameter int unsigned CTL_W    = 32,
   parameter int unsigned TYPE_LSB = 3,
   parameter int unsigned MASK_LSB = 24,
   parameter int unsigned MASK_W   = 4,
   parameter int unsigned BAS_LSB  = 5,
   parameter int unsigned BAS_W    = 8
) (
   input  logic [VA_W-1:0]  val_q,
   input  logic [CTL_W-1:0] ctl_q,
   output wfilt_t           filt,
   output logic [VA_W:0]    win_lo,
   output logic [VA_W:0]    win_hi
);
   localparam int unsigned IDX_W  = $clog2(BAS_W);
   localparam int unsigned HALF   = BAS_W / 2;
   localparam int unsigned MIN_MK = 3;

   function automatic logic [IDX_W-1:0] first_one(input logic [BAS_W-1:0] b);
      first_one = '0;
      for (int i = BAS_W - 1; i >= 0; i--)
         if (b[i]) first_one = IDX_W'(i);
   endfunction

   function automatic logic [IDX_W:0] run_len(input logic [BAS_W-1:0] b);
      logic stop;
      stop    = 1'b0;
      run_len = '0;
      for (int i = 0; i < BAS_W; i++) begin
         if (!stop) begin
            if (b[i]) run_len = run_len + 1'b1;
            else      stop    = 1'b1;
         end
      end
   endfunction

   logic [MASK_W-1:0] msz;
   logic [BAS_W-1:0]  bas_raw, bas_eff;
   logic [IDX_W-1:0]  start;
   logic [IDX_W:0]    run;
   logic [VA_W:0]     span, mask_lo, bas_lo;
   logic              use_mask, mask_resv, bas_empty;
   wtype_e            kind;

   assign msz     = ctl_q[MASK_LSB +: MASK_W];
   assign bas_raw = ctl_q[BAS_LSB +: BAS_W];
   assign kind    = wtype_e'(ctl_q[TYPE_LSB +: 2]);

   // a 4-aligned value only keeps the lower half of the select field
   assign bas_eff = val_q[2] ? {{(BAS_W - HALF){1'b0}}, bas_raw[HALF-1:0]}
                             : bas_raw;
   assign start   = first_one(bas_eff);
   assign run     = run_len(bas_eff >> start);

   assign span    = {{VA_W{1'b0}}, 1'b1} << msz;
   assign mask_lo = {1'b0, val_q} & ~(span - 1'b1);
   assign bas_lo  = {1'b0, val_q} + (VA_W + 1)'(start);

   assign use_mask  = msz >= MASK_W'(MIN_MK);
   assign mask_resv = (msz == MASK_W'(1)) || (msz == MASK_W'(2));
   assign bas_empty = (msz == '0) && (bas_eff == '0);

   always_comb begin
      if (use_mask) begin
         win_lo = mask_lo;
         win_hi = mask_lo + span - 1'b1;
      end else begin
         win_lo = bas_lo;
         win_hi = bas_lo + (VA_W + 1)'(run) - 1'b1;
      end
   end

   assign filt.armed = ctl_q[0] && (kind != WT_NONE) && !mask_resv && !bas_empty;
   assign filt.rd_ok = (kind == WT_LOAD)  || (kind == WT_ANY);
   assign filt.wr_ok = (kind == WT_STORE) || (kind == WT_ANY);
endmodule

// File: rtl/wpt_match.sv
module wpt_match
   import wpt_pkg::*;
#(
   parameter int unsigned VA_W = 64,
   parameter int unsigned SZ_W = 4
) (
   input  wfilt_t          filt,
   input  logic [VA_W:0]   win_lo,
   input  logic [VA_W:0]   win_hi,
   input  logic            acc_valid,
   input  logic [VA_W-1:0] acc_addr,
   input  logic [SZ_W-1:0] acc_size,
   input  logic            acc_is_store,
   output logic            hit
);
   logic [VA_W:0] acc_lo, acc_hi;
   logic          kind_ok, overlap;

   // one extra bit keeps the end of the access from wrapping
   assign acc_lo  = {1'b0, acc_addr};
   assign acc_hi  = acc_lo + (VA_W + 1)'(acc_size) - 1'b1;
   assign kind_ok = acc_is_store ? filt.wr_ok : filt.rd_ok;
   assign overlap = (acc_size != '0) && (acc_lo <= win_hi) && (acc_hi >= win_lo);
   assign hit     = acc_valid && filt.armed && kind_ok && overlap;
endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
   import wpt_pkg::*;
#(
   parameter int unsigned VA_W     = 64,
   parameter int unsigned SEXT_BIT = 48,
   parameter int unsigned CTL_W    = 32,
   parameter int unsigned SZ_W     = 4,
   parameter int unsigned TYPE_LSB = 3,
   parameter int unsigned MASK_LSB = 24,
   parameter int unsigned MASK_W   = 4,
   parameter int unsigned BAS_LSB  = 5,
   parameter int unsigned BAS_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             val_we,
   input  logic [VA_W-1:0]  val_wdata,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             acc_valid,
   input  logic [VA_W-1:0]  acc_addr,
   input  logic [SZ_W-1:0]  acc_size,
   input  logic             acc_is_store,
   output logic             hit
);
   localparam int unsigned MAX_REGION_LOG = (1 << MASK_W) - 1;

   initial begin
      assert (SEXT_BIT < VA_W && SEXT_BIT >= 3)
         else $error("wpt_cmp: SEXT_BIT out of range");
      assert (MAX_REGION_LOG < VA_W)
         else $error("wpt_cmp: mask region wider than address");
      assert (MASK_LSB + MASK_W <= CTL_W && BAS_LSB + BAS_W <= CTL_W)
         else $error("wpt_cmp: control fields exceed control width");
      assert (BAS_W >= 2 && (BAS_W & (BAS_W - 1)) == 0)
         else $error("wpt_cmp: BAS_W must be a power of two");
   end

   logic [VA_W-1:0]  val_q;
   logic [CTL_W-1:0] ctl_q;
   wfilt_t           filt;
   logic [VA_W:0]    win_lo, win_hi;

   wpt_regs #(.VA_W(VA_W), .SEXT_BIT(SEXT_BIT), .CTL_W(CTL_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .val_we(val_we), .val_wdata(val_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .val_q(val_q), .ctl_q(ctl_q)
   );

   wpt_decode #(
      .VA_W(VA_W), .CTL_W(CTL_W), .TYPE_LSB(TYPE_LSB), .MASK_LSB(MASK_LSB),
      .MASK_W(MASK_W), .BAS_LSB(BAS_LSB), .BAS_W(BAS_W)
   ) u_decode (
      .val_q(val_q), .ctl_q(ctl_q),
      .filt(filt), .win_lo(win_lo), .win_hi(win_hi)
   );

   wpt_match #(.VA_W(VA_W), .SZ_W(SZ_W)) u_match (
      .filt(filt), .win_lo(win_lo), .win_hi(win_hi),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_is_store(acc_is_store), .hit(hit)
   );
endmodule

// File: rtl/wpt_cmp_chk.sv
module wpt_cmp_chk #(
   parameter int unsigned VA_W     = 64,
   parameter int unsigned SEXT_BIT = 48,
   parameter int unsigned CTL_W    = 32,
   parameter int unsigned SZ_W     = 4,
   parameter int unsigned TYPE_LSB = 3,
   parameter int unsigned MASK_LSB = 24,
   parameter int unsigned MASK_W   = 4,
   parameter int unsigned BAS_LSB  = 5,
   parameter int unsigned BAS_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic             acc_valid,
   input logic [SZ_W-1:0]  acc_size,
   input logic             acc_is_store,
   input logic [VA_W-1:0]  val_q,
   input logic [CTL_W-1:0] ctl_q,
   input logic             hit
);
   localparam int unsigned EXT_N = VA_W - SEXT_BIT;

   a_r1_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[0] |-> !hit);

   a_r2_type_filter: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (acc_is_store ? ctl_q[TYPE_LSB + 1] : ctl_q[TYPE_LSB]));

   a_r3_mask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_q[MASK_LSB +: MASK_W] == MASK_W'(1)) ||
       (ctl_q[MASK_LSB +: MASK_W] == MASK_W'(2))) |-> !hit);

   a_r5_select_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_q[MASK_LSB +: MASK_W] == '0) && (ctl_q[BAS_LSB +: BAS_W] == '0)) |-> !hit);

   a_r8_value_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q[1:0] == 2'b00) && (val_q[VA_W-1:SEXT_BIT] == {EXT_N{val_q[SEXT_BIT]}}));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid || acc_size == '0) |-> !hit);

   a_r11_ctl_update: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (ctl_q == $past(ctl_wdata)));

   a_r11_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_q));
endmodule

bind wpt_cmp wpt_cmp_chk #(
   .VA_W(VA_W), .SEXT_BIT(SEXT_BIT), .CTL_W(CTL_W), .SZ_W(SZ_W),
   .TYPE_LSB(TYPE_LSB), .MASK_LSB(MASK_LSB), .MASK_W(MASK_W),
   .BAS_LSB(BAS_LSB), .BAS_W(BAS_W)
) u_wpt_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
   .acc_valid(acc_valid), .acc_size(acc_size), .acc_is_store(acc_is_store),
   .val_q(val_q), .ctl_q(ctl_q), .hit(hit)
);

// File: tb/test_wpt_cmp.sv
module test_wpt_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        val_we = 1'b0;
   logic [63:0] val_wdata = '0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [63:0] acc_addr = '0;
   logic [3:0]  acc_size = '0;
   logic        acc_is_store = 1'b0;
   logic        hit;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic [63:0] sh_val = '0;
   logic [31:0] sh_ctl = '0;

   always #2 clk = ~clk;   // 250 MHz

   wpt_cmp i_wpt_cmp (
      .clk(clk), .rst_n(rst_n), .val_we(val_we), .val_wdata(val_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_is_store(acc_is_store),
      .hit(hit)
   );

   // R8: value register keeps bits [48:2], sign-extends bit 48, zeroes [1:0]
   function automatic logic [63:0] cond_val(input logic [63:0] w);
      return {{15{w[48]}}, w[48:2], 2'b00};
   endfunction

   function automatic logic [31:0] mk_ctl(input bit en, input int typ,
                                          input int msz, input int bas);
      logic [31:0] c = '0;
      c[0]     = en;
      c[4:3]   = 2'(typ);
      c[12:5]  = 8'(bas);
      c[27:24] = 4'(msz);
      return c;
   endfunction

   // reference model written from R1..R9
   function automatic bit exp_hit(input logic [63:0] v, input logic [31:0] c,
                                  input bit vld, input logic [63:0] a,
                                  input int s, input bit st);
      int m = int'(c[27:24]);
      logic [7:0] b = c[12:5];
      logic [7:0] r = '0;
      int first = -1;
      if (!vld || s == 0) return 0;
      if (!c[0] || c[4:3] == 2'b00) return 0;
      if (st && !c[4]) return 0;
      if (!st && !c[3]) return 0;
      if (m == 1 || m == 2) return 0;
      if (m == 0) begin
         if (v[2]) b[7:4] = 4'h0;
         if (b == 8'h00) return 0;
         for (int i = 0; i < 8; i++) if (first < 0 && b[i]) first = i;
         for (int i = first; i < 8; i++) begin
            if (!b[i]) break;
            r[i] = 1'b1;
         end
      end
      for (int k = 0; k < s; k++) begin
         logic [63:0] x = a + 64'(k);
         if (m >= 3) begin
            if ((x >> m) == (v >> m)) return 1;
         end else begin
            logic [63:0] off = x - v;
            if (off < 64'd8 && r[off[2:0]]) return 1;
         end
      end
      return 0;
   endfunction

   task automatic check(input string req, input bit exp_v);
      n_checks++;
      if (hit !== exp_v) begin
         n_errors++;
         $display("FAIL %s: hit=%0b expected %0b (addr=%h size=%0d st=%0b ctl=%h val=%h)",
                  req, hit, exp_v, acc_addr, acc_size, acc_is_store, sh_ctl, sh_val);
      end
   endtask

   task automatic wr_val(input logic [63:0] v);
      @(negedge clk);
      val_we = 1'b1; val_wdata = v;
      @(negedge clk);
      val_we = 1'b0;
      sh_val = cond_val(v);
   endtask

   task automatic wr_ctl(input logic [31:0] c);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = c;
      @(negedge clk);
      ctl_we = 1'b0;
      sh_ctl = c;
   endtask

   // drive an access after a falling edge and look at hit before the next rise
   task automatic probe(input string req, input logic [63:0] a, input int s,
                        input bit st, input bit exp_v);
      acc_valid = 1'b1; acc_addr = a; acc_size = 4'(s); acc_is_store = st;
      #1;
      check(req, exp_v);
   endtask

   task automatic probe_model(input string req, input logic [63:0] a,
                              input int s, input bit st);
      probe(req, a, s, st, exp_hit(sh_val, sh_ctl, 1'b1, a, s, st));
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = 7;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state has no hit even with a full access at address 0
      @(negedge clk);
      probe("R11 reset", 64'h0, 8, 0, 0);
      probe("R11 reset", 64'h0, 8, 1, 0);

      // R1: disarmed control never hits, arming makes it hit
      wr_val(64'h1000);
      wr_ctl(mk_ctl(0, 3, 0, 8'hFF));
      probe("R1 disarmed", 64'h1000, 4, 0, 0);
      wr_ctl(mk_ctl(1, 3, 0, 8'hFF));
      probe("R1 armed", 64'h1000, 4, 0, 1);

      // R2: access kind filter
      wr_ctl(mk_ctl(1, 1, 0, 8'hFF));
      probe("R2 load-only load", 64'h1002, 1, 0, 1);
      probe("R2 load-only store", 64'h1002, 1, 1, 0);
      wr_ctl(mk_ctl(1, 2, 0, 8'hFF));
      probe("R2 store-only load", 64'h1002, 1, 0, 0);
      probe("R2 store-only store", 64'h1002, 1, 1, 1);
      wr_ctl(mk_ctl(1, 0, 0, 8'hFF));
      probe("R2 type 00", 64'h1002, 1, 1, 0);

      // R3: reserved mask sizes disarm; 3 works
      wr_ctl(mk_ctl(1, 3, 1, 8'hFF));
      probe("R3 mask 1", 64'h1000, 1, 0, 0);
      wr_ctl(mk_ctl(1, 3, 2, 8'hFF));
      probe("R3 mask 2", 64'h1000, 1, 0, 0);
      wr_ctl(mk_ctl(1, 3, 3, 8'h00));
      probe("R3 mask 3", 64'h1007, 1, 0, 1);

      // R4: 4 KiB region, value low bits ignored, byte-select ignored
      wr_val(64'h12345);
      wr_ctl(mk_ctl(1, 3, 12, 8'h00));
      probe("R4 region start", 64'h12000, 1, 0, 1);
      probe("R4 region end", 64'h12FFF, 1, 1, 1);
      probe("R4 above region", 64'h13000, 4, 0, 0);
      probe("R4 below region", 64'h11FFF, 1, 0, 0);
      probe("R4 straddle low", 64'h11FFF, 2, 0, 1);

      // R5: empty byte-select disarms
      wr_val(64'h2000);
      wr_ctl(mk_ctl(1, 3, 0, 8'h00));
      probe("R5 empty select", 64'h2000, 8, 0, 0);
      wr_ctl(mk_ctl(1, 3, 0, 8'h80));
      probe("R5 top byte", 64'h2007, 1, 0, 1);
      probe("R5 byte 6 miss", 64'h2006, 1, 0, 0);

      // R6: 4-aligned value uses only select bits [3:0]
      wr_val(64'h2004);
      wr_ctl(mk_ctl(1, 3, 0, 8'hF0));
      probe("R6 upper half dropped", 64'h2004, 8, 0, 0);
      wr_ctl(mk_ctl(1, 3, 0, 8'h12));
      probe("R6 byte 1 kept", 64'h2005, 1, 0, 1);
      probe("R6 byte 4 dropped", 64'h2008, 1, 0, 0);

      // R7: first run only (bits 2,3 of 0110_1100)
      wr_val(64'h3000);
      wr_ctl(mk_ctl(1, 3, 0, 8'b0110_1100));
      probe("R7 run start", 64'h3002, 1, 0, 1);
      probe("R7 run end", 64'h3003, 1, 0, 1);
      probe("R7 gap", 64'h3004, 1, 0, 0);
      probe("R7 stray bit", 64'h3005, 1, 0, 0);
      probe("R7 below run", 64'h3001, 1, 0, 0);

      // R8: low bits cleared, bit 48 extended
      wr_val(64'h1003);
      wr_ctl(mk_ctl(1, 3, 0, 8'h01));
      probe("R8 low bits cleared", 64'h1000, 1, 0, 1);
      probe("R8 low bits cleared", 64'h1003, 1, 0, 0);
      wr_val(64'h0001_0000_0000_0040);
      probe("R8 sign extension", 64'hFFFF_0000_0000_0040, 1, 0, 1);
      probe("R8 sign extension", 64'h0001_0000_0000_0040, 1, 0, 0);

      // R9: overlap by partial bytes, zero size, invalid
      wr_val(64'h1000);
      wr_ctl(mk_ctl(1, 3, 0, 8'h01));
      probe("R9 tail overlap", 64'h0FFE, 4, 0, 1);
      probe("R9 ends before", 64'h0FFE, 2, 0, 0);
      probe("R9 size 0", 64'h1000, 0, 0, 0);
      acc_valid = 1'b0; #1;
      check("R9 not valid", 0);

      // R10: hit follows the access within the same cycle
      @(negedge clk);
      probe("R10 same-cycle rise", 64'h1000, 1, 0, 1);
      #1 acc_addr = 64'h1001; #1;
      check("R10 same-cycle fall", 0);

      // R11: write takes effect only after the write edge
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = mk_ctl(0, 3, 0, 8'h01);
      probe("R11 old setting in write cycle", 64'h1000, 1, 0, 1);
      @(negedge clk);
      ctl_we = 1'b0; sh_ctl = ctl_wdata;
      #1;
      check("R11 new setting next cycle", 0);

      // random phase checked against the model (R9 with R2..R7 mixed in)
      for (int it = 0; it < 1500; it++) begin
         logic [63:0] v;
         int typ, msz, bas, span;
         v = {24'h0, 8'h00, 32'h0001_0000 + $urandom_range(0, 32'h00FF_FFFF)};
         if ($urandom_range(0, 7) == 0) v[48] = 1'b1;
         typ = $urandom_range(0, 3);
         msz = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 15);
         bas = $urandom_range(0, 255);
         wr_val(v);
         wr_ctl(mk_ctl($urandom_range(0, 7) != 0, typ, msz, bas));
         span = (msz >= 3) ? (1 << msz) : 8;
         for (int p = 0; p < 4; p++) begin
            logic [63:0] a;
            int d = $urandom_range(0, span + 32) - 16;
            if (msz >= 3 && p == 0) d = -int'(sh_val & 64'(span - 1)) - $urandom_range(0, 3);
            a = sh_val + 64'(signed'(d));
            probe_model("R9 random", a, $urandom_range(0, 15), 1'($urandom_range(0, 1)));
         end
      end

      acc_valid = 1'b0;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule